// File: doc/BRIEF.md
# Arithmetic Unit with Bit-Count and Random Source

This block is the arithmetic execution stage of a small 32-bit RISC core. Each cycle it takes an operation code, a first operand and a second operand. The second operand is either a register value or a 16-bit immediate. At the next clock edge it presents a registered result word and a carry flag.

Besides addition, subtraction, an optional multiplier, logical shifts and rotates, it offers three bit-statistics operations on the first operand: the number of ones, the number of zeros, and the number of places where neighbouring bits differ. It also has a pseudo-random source. This source is a 32-bit maximal-length LFSR that steps only in cycles that request it.

The core decodes an instruction into `op_sel`, `use_imm` and the operand buses, then takes `result` and `carry` one cycle later for write-back.

Top module: `arith_unit`

## Requirements
- R1: With `rst` high at a clock edge, `result` and `carry` become 0 and the LFSR loads `LFSR_SEED` without stepping.
- R2: Every output is registered. The inputs present at edge k determine `result`/`carry` after edge k. For ADD (code 0), `result` is the low 32 bits of A+B and `carry` is the carry-out of the addition.
- R3: For SUB (code 1), `result` is A−B modulo 2^32 and `carry` is 1 when A ≥ B unsigned, meaning no borrow occurred.
- R4: When `use_imm` is 1, operand B is `imm` instead of `opb_reg`. The immediate is sign-extended for codes 0 and 1 and zero-extended for every other code.
- R5: MUL (code 2) and MULU (code 3) return the low 32 bits of A×B. When `HAS_MUL` is 0, both codes return 0.
- R6: SHR (code 4) and SHL (code 5) are logical shifts of A. The shift amount is B[4:0], and higher bits of B are ignored.
- R7: ROR (code 6) and ROL (code 7) rotate A by B[4:0] positions.
- R8: PCNT (code 8) returns the number of 1 bits in A.
- R9: PCNTZ (code 9) returns the number of 0 bits in A.
- R10: PCNTC (code 10) returns the number of indices i in 0..30 with A[i] ≠ A[i+1].
- R11: RND (code 11) returns the current LFSR state. In that same edge the state advances to {s[30:0], s[31]^s[21]^s[1]^s[0]}. In any cycle with another code, the state holds.
- R12: Codes 12 to 15 return a result of 0 and a carry of 0.
- R13: `carry` is 0 after any code other than 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | 1 selects `imm` as operand B |
| opa | input | 32 | Operand A |
| opb_reg | input | 32 | Operand B from a register |
| imm | input | 16 | Immediate field |
| result | output | 32 | Registered result word |
| carry | output | 1 | Registered carry flag |

## Verification
The bench builds two copies side by side on the same stimulus. The first uses the default multiplier (`HAS_MUL`=1) and an explicit non-trivial seed, so the product values and a known random sequence can be checked. The second uses `HAS_MUL`=0, which brings the zero result of the multiply codes within reach while every other code must match the first copy. Both copies share the seed, so the stepping of the random source, its hold during other codes and its reload on reset are compared against an independent model of the feedback polynomial.

// File: rtl/au_pkg.sv
package au_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MUL   = 4'd2,
    OP_MULU  = 4'd3,
    OP_SHR   = 4'd4,
    OP_SHL   = 4'd5,
    OP_ROR   = 4'd6,
    OP_ROL   = 4'd7,
    OP_PCNT  = 4'd8,
    OP_PCNTZ = 4'd9,
    OP_PCNTC = 4'd10,
    OP_RND   = 4'd11
  } au_op_e;

  // Low two code bits select the shifter variant for codes 4..7
  typedef enum logic [1:0] {
    SH_RIGHT  = 2'd0,
    SH_LEFT   = 2'd1,
    ROT_RIGHT = 2'd2,
    ROT_LEFT  = 2'd3
  } au_shmode_e;

endpackage

// File: rtl/au_bitcount.sv
module au_bitcount #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a,
  output logic [CW-1:0] ones,
  output logic [CW-1:0] flips
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(a[i]);
    end
  end

  always_comb begin
    flips = '0;
    for (int i = 0; i < W - 1; i++) begin
      flips = flips + CW'(a[i] ^ a[i+1]);
    end
  end

endmodule

// File: rtl/au_shift_rot.sv
module au_shift_rot
  import au_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  input  logic [1:0]      mode,
  output logic [W-1:0]    y
);

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_r;
  logic [2*W-1:0] dbl_l;

  assign dbl   = {a, a};
  assign dbl_r = dbl >> amt;
  assign dbl_l = dbl << amt;

  always_comb begin
    case (au_shmode_e'(mode))
      SH_RIGHT:  y = a >> amt;
      SH_LEFT:   y = a << amt;
      ROT_RIGHT: y = dbl_r[W-1:0];
      default:   y = dbl_l[2*W-1:W];
    endcase
  end

endmodule

// File: rtl/au_lfsr.sv
module au_lfsr #(
  parameter int           W    = 32,
  parameter logic [W-1:0] SEED = W'(1),
  parameter logic [W-1:0] TAPS = W'(32'h8020_0003)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);

  logic         fb;
  logic [W-1:0] state_nx;

  assign fb       = ^(state & TAPS);
  assign state_nx = {state[W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (step) begin
      state <= state_nx;
    end
  end

endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import au_pkg::*;
#(
  parameter int              WIDTH     = 32,
  parameter int              IMM_W     = 16,
  parameter bit              HAS_MUL   = 1'b1,
  parameter logic [WIDTH-1:0] LFSR_SEED = WIDTH'(1),
  parameter logic [WIDTH-1:0] LFSR_TAPS = WIDTH'(32'h8020_0003)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic             use_imm,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb_reg,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             carry
);

  localparam int CW   = $clog2(WIDTH + 1);
  localparam int SH_W = $clog2(WIDTH);
  localparam int PADW = WIDTH - CW;

  // Operand B selection
  logic             is_addsub;
  logic [WIDTH-1:0] imm_sx;
  logic [WIDTH-1:0] imm_zx;
  logic [WIDTH-1:0] opb;

  assign is_addsub = (op_sel == OP_ADD) || (op_sel == OP_SUB);
  assign imm_sx    = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_zx    = {{(WIDTH-IMM_W){1'b0}}, imm};
  assign opb       = !use_imm ? opb_reg : (is_addsub ? imm_sx : imm_zx);

  // Adder / subtractor with carry out
  logic [WIDTH:0] sum_w;
  logic [WIDTH:0] diff_w;

  assign sum_w  = {1'b0, opa} + {1'b0, opb};
  assign diff_w = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, 1'b1};

  // Optional multiplier: low word is the same for signed and unsigned
  logic [WIDTH-1:0] mul_lo;

  generate
    if (HAS_MUL) begin : g_mul
      assign mul_lo = opa * opb;
    end else begin : g_nomul
      assign mul_lo = '0;
    end
  endgenerate

  // Shifter / rotator
  logic [WIDTH-1:0] shr_y;

  au_shift_rot #(
    .W    (WIDTH),
    .SH_W (SH_W)
  ) u_shift (
    .a    (opa),
    .amt  (opb[SH_W-1:0]),
    .mode (op_sel[1:0]),
    .y    (shr_y)
  );

  // Bit statistics
  logic [CW-1:0] ones_cnt;
  logic [CW-1:0] flip_cnt;
  logic [CW-1:0] zero_cnt;

  au_bitcount #(
    .W  (WIDTH),
    .CW (CW)
  ) u_count (
    .a     (opa),
    .ones  (ones_cnt),
    .flips (flip_cnt)
  );

  assign zero_cnt = CW'(WIDTH) - ones_cnt;

  // Random source
  logic             lfsr_step;
  logic [WIDTH-1:0] lfsr_q;

  assign lfsr_step = (op_sel == OP_RND);

  au_lfsr #(
    .W    (WIDTH),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .step  (lfsr_step),
    .state (lfsr_q)
  );

  // Result select
  logic [WIDTH-1:0] res_nx;
  logic             cy_nx;

  always_comb begin
    res_nx = '0;
    cy_nx  = 1'b0;
    case (op_sel)
      OP_ADD: begin
        res_nx = sum_w[WIDTH-1:0];
        cy_nx  = sum_w[WIDTH];
      end
      OP_SUB: begin
        res_nx = diff_w[WIDTH-1:0];
        cy_nx  = diff_w[WIDTH];
      end
      OP_MUL, OP_MULU:                 res_nx = mul_lo;
      OP_SHR, OP_SHL, OP_ROR, OP_ROL:  res_nx = shr_y;
      OP_PCNT:                         res_nx = {{PADW{1'b0}}, ones_cnt};
      OP_PCNTZ:                        res_nx = {{PADW{1'b0}}, zero_cnt};
      OP_PCNTC:                        res_nx = {{PADW{1'b0}}, flip_cnt};
      OP_RND:                          res_nx = lfsr_q;
      default: begin
        res_nx = '0;
        cy_nx  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      carry  <= 1'b0;
    end else begin
      result <= res_nx;
      carry  <= cy_nx;
    end
  end

endmodule

// File: rtl/au_checker.sv
module au_checker #(
  parameter int WIDTH   = 32,
  parameter bit HAS_MUL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry,
  input logic [WIDTH-1:0] lfsr_state
);

  // R13: no carry from non-arithmetic codes
  a_r13_carry_only_arith: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) > 4'd1) |-> (carry == 1'b0));

  // R12: unused codes give zero
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) >= 4'd12) |-> (result == '0 && carry == 1'b0));

  // R8 / R9: counts cannot exceed the word width
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == 4'd8 || $past(op_sel) == 4'd9))
      |-> (result <= WIDTH'(WIDTH)));

  // R10: at most WIDTH-1 transitions
  a_r10_change_bound: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'd10) |-> (result < WIDTH'(WIDTH)));

  // R11: state holds unless the random code is selected
  a_r11_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
    (op_sel != 4'd11) |=> $stable(lfsr_state));

  // R11: random code returns the state held during the request
  a_r11_rnd_value: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd11) |=> (result == $past(lfsr_state)));

  // R11: a maximal-length LFSR never reaches all zeros
  a_r11_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    (lfsr_state != '0));

  generate
    if (!HAS_MUL) begin : g_nomul_chk
      // R5: multiply codes return zero when the multiplier is left out
      a_r5_nomul_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_sel) == 4'd2 || $past(op_sel) == 4'd3))
          |-> (result == '0));
    end
  endgenerate

endmodule

bind arith_unit au_checker #(
  .WIDTH   (WIDTH),
  .HAS_MUL (HAS_MUL)
) u_au_checker (
  .clk        (clk),
  .rst        (rst),
  .op_sel     (op_sel),
  .result     (result),
  .carry      (carry),
  .lfsr_state (lfsr_q)
);

// File: tb/arith_unit_bench.sv
module arith_unit_bench;

  localparam logic [31:0] SEED = 32'hC0FF_EE01;
  localparam int NV = 37;

  typedef struct packed {
    logic [3:0]  op;
    logic        ui;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [31:0] res;
    logic        cy;
    logic [7:0]  req;
  } vec_t;

  // op, use_imm, a, b, imm, expected result, expected carry, requirement
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 32'h0000_000C, 1'b0, 8'd2},  // R2
    '{4'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000, 1'b1, 8'd2},  // R2
    '{4'd0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b0, 8'd2},  // R2
    '{4'd1, 1'b0, 32'h0000_000A, 32'h0000_0003, 16'h0000, 32'h0000_0007, 1'b1, 8'd3},  // R3
    '{4'd1, 1'b0, 32'h0000_0003, 32'h0000_000A, 16'h0000, 32'hFFFF_FFF9, 1'b0, 8'd3},  // R3
    '{4'd1, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0000, 1'b1, 8'd3},  // R3
    '{4'd0, 1'b1, 32'h0000_000A, 32'hDEAD_BEEF, 16'hFFFF, 32'h0000_0009, 1'b1, 8'd4},  // R4
    '{4'd1, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h0001, 32'hFFFF_FFFF, 1'b0, 8'd4},  // R4
    '{4'd1, 1'b1, 32'h0000_0005, 32'h1234_0000, 16'h8000, 32'h0000_8005, 1'b0, 8'd4},  // R4
    '{4'd3, 1'b1, 32'h0000_0002, 32'h0000_0000, 16'hFFFF, 32'h0001_FFFE, 1'b0, 8'd4},  // R4
    '{4'd2, 1'b0, 32'hFFFF_FFFF, 32'h0000_0003, 16'h0000, 32'hFFFF_FFFD, 1'b0, 8'd5},  // R5
    '{4'd3, 1'b0, 32'h0001_0000, 32'h0001_0000, 16'h0000, 32'h0000_0000, 1'b0, 8'd5},  // R5
    '{4'd2, 1'b0, 32'h0000_04D2, 32'h0000_0064, 16'h0000, 32'h0001_E208, 1'b0, 8'd5},  // R5
    '{4'd4, 1'b0, 32'h8000_0000, 32'h0000_001F, 16'h0000, 32'h0000_0001, 1'b0, 8'd6},  // R6
    '{4'd4, 1'b0, 32'h0000_00F0, 32'h0000_0024, 16'h0000, 32'h0000_000F, 1'b0, 8'd6},  // R6
    '{4'd5, 1'b0, 32'h0000_0001, 32'h0000_0020, 16'h0000, 32'h0000_0001, 1'b0, 8'd6},  // R6
    '{4'd5, 1'b0, 32'h1234_5678, 32'h0000_0008, 16'h0000, 32'h3456_7800, 1'b0, 8'd6},  // R6
    '{4'd4, 1'b1, 32'hFFFF_0000, 32'h0000_0000, 16'h0010, 32'h0000_FFFF, 1'b0, 8'd6},  // R6
    '{4'd6, 1'b0, 32'h0000_0001, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b0, 8'd7},  // R7
    '{4'd7, 1'b0, 32'h8000_0001, 32'h0000_0004, 16'h0000, 32'h0000_0018, 1'b0, 8'd7},  // R7
    '{4'd6, 1'b0, 32'h1234_5678, 32'h0000_0008, 16'h0000, 32'h7812_3456, 1'b0, 8'd7},  // R7
    '{4'd7, 1'b0, 32'h1234_5678, 32'h0000_003F, 16'h0000, 32'h091A_2B3C, 1'b0, 8'd7},  // R7
    '{4'd8, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0, 8'd8},  // R8
    '{4'd8, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 32'h0000_0020, 1'b0, 8'd8},  // R8
    '{4'd8, 1'b0, 32'h0000_F0F0, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0008, 1'b0, 8'd8},  // R8
    '{4'd8, 1'b1, 32'h0000_000F, 32'h0000_0000, 16'hFFFF, 32'h0000_0004, 1'b0, 8'd8},  // R8
    '{4'd9, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0020, 1'b0, 8'd9},  // R9
    '{4'd9, 1'b0, 32'h8000_0001, 32'h0000_0000, 16'h0000, 32'h0000_001E, 1'b0, 8'd9},  // R9
    '{4'd9, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0, 8'd9},  // R9
    '{4'd10, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0, 8'd10}, // R10
    '{4'd10, 1'b0, 32'h5555_5555, 32'h0000_0000, 16'h0000, 32'h0000_001F, 1'b0, 8'd10}, // R10
    '{4'd10, 1'b0, 32'hFFFF_0000, 32'h0000_0000, 16'h0000, 32'h0000_0001, 1'b0, 8'd10}, // R10
    '{4'd10, 1'b0, 32'h8000_0001, 32'h0000_0000, 16'h0000, 32'h0000_0002, 1'b0, 8'd10}, // R10
    '{4'd12, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 1'b0, 8'd12}, // R12
    '{4'd15, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000, 1'b0, 8'd12}, // R12
    '{4'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'hFFFF_FFFE, 1'b1, 8'd2},  // R2
    '{4'd5, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'hFFFF_FFFE, 1'b0, 8'd13}  // R13
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = 4'd0;
  logic        use_imm = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb_reg = '0;
  logic [15:0] imm = '0;
  logic [31:0] result, result_nm;
  logic        carry, carry_nm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  arith_unit #(.HAS_MUL(1'b1), .LFSR_SEED(SEED)) u_arith_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .use_imm(use_imm), .opa(opa),
    .opb_reg(opb_reg), .imm(imm), .result(result), .carry(carry));

  arith_unit #(.HAS_MUL(1'b0), .LFSR_SEED(SEED)) u_arith_unit_nomul (
    .clk(clk), .rst(rst), .op_sel(op_sel), .use_imm(use_imm), .opa(opa),
    .opb_reg(opb_reg), .imm(imm), .result(result_nm), .carry(carry_nm));

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive just after an edge, sample just after the following edge
  task automatic step(input logic [3:0] op, input logic ui, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im);
    op_sel = op; use_imm = ui; opa = a; opb_reg = b; imm = im;
    @(posedge clk); #1;
  endtask

  logic [31:0] model;

  initial begin
    rst = 1'b1;
    op_sel = 4'd11; opa = 32'hFFFF_FFFF; opb_reg = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 result after reset", result, 32'h0);
    check("R1 carry after reset", {31'b0, carry}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].ui, VECS[i].a, VECS[i].b, VECS[i].im);
      check($sformatf("R%0d vector %0d result", VECS[i].req, i), result, VECS[i].res);
      check($sformatf("R%0d vector %0d carry", VECS[i].req, i), {31'b0, carry}, {31'b0, VECS[i].cy});
      // R5: without multiplier, codes 2/3 give zero; all else matches
      if (VECS[i].op == 4'd2 || VECS[i].op == 4'd3)
        check($sformatf("R5 no-mul vector %0d", i), result_nm, 32'h0);
      else
        check($sformatf("R%0d no-mul vector %0d", VECS[i].req, i), result_nm, VECS[i].res);
    end

    // R11: random sequence starts at the seed (no RND used yet)
    model = SEED;
    for (int k = 0; k < 5; k++) begin
      step(4'd11, 1'b0, 32'h0, 32'h0, 16'h0);
      check("R11 rnd sequence", result, model);
      check("R11 rnd carry R13", {31'b0, carry}, 32'h0);
      check("R11 rnd no-mul copy", result_nm, model);
      model = lfsr_next(model);
    end
    // R11: other codes leave the state untouched
    for (int k = 0; k < 3; k++) step(4'd0, 1'b0, 32'h1, 32'h1, 16'h0);
    step(4'd11, 1'b0, 32'h0, 32'h0, 16'h0);
    check("R11 rnd resumes after hold", result, model);
    model = lfsr_next(model);
    step(4'd11, 1'b0, 32'h0, 32'h0, 16'h0);
    check("R11 rnd next after resume", result, model);

    // R1: reset mid-run with RND requested reloads the seed, no step
    op_sel = 4'd11;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 result cleared", result, 32'h0);
    rst = 1'b0;
    step(4'd11, 1'b0, 32'h0, 32'h0, 16'h0);
    check("R1 seed reloaded", result, SEED);
    step(4'd11, 1'b0, 32'h0, 32'h0, 16'h0);
    check("R11 step after reload", result, lfsr_next(SEED));

    // R2: a carry is held only one cycle, R13 clears it
    step(4'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'h0);
    check("R2 carry out", {31'b0, carry}, 32'h1);
    step(4'd13, 1'b0, 32'h8000_0000, 32'h8000_0000, 16'h0);
    check("R12 carry cleared", {31'b0, carry}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule